// File: doc/BRIEF.md
# Shared-Function I/O Pin Controller

This block is the digital control for one I/O pin that several functions share: plain port data, an I2C clock line, a timer output, a pin-change interrupt input, a set of analog channel inputs and an analog reference input. It holds the pin's port configuration (direction, output data, pull-up and open-drain bits). From that configuration and the live function enables, it decides which function owns the pin. It then produces the pad controls: output enable, output value, pull-up enable and input-buffer enable.

The raw pad input passes through a gate controlled by the input-buffer enable. The gated value goes to the port read path, to the I2C clock input and to the pin-change interrupt input. While the buffer is off, every consumer sees a clean 0. Configuration bits load together on a write strobe and take effect on the following clock. The function enables act at once through combinational logic.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, direction is input and every configuration bit is 0. So `pad_oe`=0 and `pad_pu`=0, and with no function enabled `pad_ie` follows the read strobe.
- R2: `pad_pu` equals the stored pull-up bit, whatever the direction or the function enables.
- R3: The selected output value has a fixed priority. First `scl_out` when I2C is effectively enabled. Next `tmr_out` when the timer enable is effectively set. Last the stored data bit.
- R4: In push-pull mode (open-drain bit 0 and I2C not effective), with direction 1 and no blocking function, `pad_oe`=1 and `pad_out` equals the selected value.
- R5: In open-drain mode, `pad_out` is 0. `pad_oe` is 1 only when direction is 1, nothing blocks the driver and the selected value is 0.
- R6: An effective I2C enable puts the pin in open-drain mode even when the open-drain bit is 0.
- R7: An effective pin-change interrupt enable, any effective analog channel, or the analog reference forces `pad_oe`=0, whatever the direction bit.
- R8: With I2C or pin-change interrupt effective and no analog function, `pad_ie`=1 continuously.
- R9: With no secondary or analog function active, `pad_ie`=1 exactly while `cpu_rd_n` is 0.
- R10: Any effective analog channel forces `pad_ie`=0, and this takes priority over R8 and R9.
- R11: With `aref_en`=1, the effective analog selections `an_eff` are all 0. The I2C, timer and pin-change functions are ignored, and `pad_oe`=0 and `pad_ie`=0.
- R12: `port_rdata` equals `pad_in` gated by `pad_ie`. `scl_in` and `pci_in` also carry the gated value, and each is 0 when its own function is not effective.
- R13: The configuration bits change only on a clock edge with `cfg_we`=1. They then take the `wr_*` values, which are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration bits |
| wr_dir | input | 1 | Direction to load (1 = output) |
| wr_data | input | 1 | Port output data to load |
| wr_pull | input | 1 | Pull-up bit to load |
| wr_od | input | 1 | Open-drain bit to load |
| i2c_en | input | 1 | I2C clock function enable |
| scl_out | input | 1 | Clock value from the I2C peripheral |
| tmr_en | input | 1 | Timer output enable |
| tmr_out | input | 1 | Timer output value |
| pci_en | input | 1 | Pin-change interrupt input enable |
| an_sel | input | NUM_AN | Analog channel selections |
| aref_en | input | 1 | Analog reference function enable |
| cpu_rd_n | input | 1 | CPU port read strobe, active low |
| pad_in | input | 1 | Raw pad input level |
| pad_oe | output | 1 | Pad output driver enable |
| pad_out | output | 1 | Pad output value |
| pad_pu | output | 1 | Pad pull-up enable |
| pad_ie | output | 1 | Pad input buffer enable |
| port_rdata | output | 1 | Gated input for the port read path |
| scl_in | output | 1 | Gated input for the I2C peripheral |
| pci_in | output | 1 | Gated input for the pin-change detector |
| an_eff | output | NUM_AN | Effective analog channel enables |

## Verification
First, an exhaustive sweep applies every combination of configuration load values, function enables, read strobe and pad level. A behavioural model computes the expected pad controls for each combination, so every priority clash between I2C, timer, pin-change, analog and reference is covered. Directed steps then isolate single cases. Push-pull against open-drain with a 0 or 1 output value shows whether the driver sinks only. I2C combined with a cleared open-drain bit shows the forced open-drain mode. The read strobe toggled in normal mode, compared with a secondary input that is enabled, shows the strobed buffer apart from the continuous one. Analog selection combined with a secondary enable, and the reference combined with all other enables, show the override order.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    typedef struct packed {
        logic dir;
        logic data;
        logic pull;
        logic od;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{dir: 1'b0, data: 1'b0, pull: 1'b0, od: 1'b0};

endpackage

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  pin_cfg_t wdata,
    output pin_cfg_t cfg_q
);

    typedef struct packed {
        pin_cfg_t cfg;
    } regs_st_t;

    regs_st_t st_d;
    regs_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
    import gpio_pin_pkg::*;
#(
    parameter int NUM_AN = 2
) (
    input  pin_cfg_t          cfg,
    input  logic              i2c_en,
    input  logic              scl_out,
    input  logic              tmr_en,
    input  logic              tmr_out,
    input  logic              pci_en,
    input  logic [NUM_AN-1:0] an_sel,
    input  logic              aref_en,
    input  logic              cpu_rd_n,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pad_pu,
    output logic              pad_ie,
    output logic              i2c_act,
    output logic              pci_act,
    output logic [NUM_AN-1:0] an_eff
);

    typedef struct packed {
        logic i2c;
        logic tmr;
        logic pci;
        logic an_any;
        logic od_mode;
        logic blocked;
        logic sel_val;
        logic drive;
    } arb_t;

    arb_t a;

    // The analog reference claims the pin and masks every other function.
    always_comb begin
        an_eff     = an_sel & {NUM_AN{~aref_en}};
        a.i2c      = i2c_en & ~aref_en;
        a.tmr      = tmr_en & ~aref_en;
        a.pci      = pci_en & ~aref_en;
        a.an_any   = |an_eff;
        a.od_mode  = cfg.od | a.i2c;
        a.blocked  = a.pci | a.an_any | aref_en;
        if (a.i2c) begin
            a.sel_val = scl_out;
        end else if (a.tmr) begin
            a.sel_val = tmr_out;
        end else begin
            a.sel_val = cfg.data;
        end
        a.drive = cfg.dir & ~a.blocked;
    end

    always_comb begin
        if (a.od_mode) begin
            pad_oe  = a.drive & ~a.sel_val;
            pad_out = 1'b0;
        end else begin
            pad_oe  = a.drive;
            pad_out = a.sel_val;
        end
        pad_pu = cfg.pull;
        if (aref_en || a.an_any) begin
            pad_ie = 1'b0;
        end else if (a.i2c || a.pci) begin
            pad_ie = 1'b1;
        end else begin
            pad_ie = ~cpu_rd_n;
        end
        i2c_act = a.i2c;
        pci_act = a.pci;
    end

endmodule

// File: rtl/gpio_pin_ingate.sv
module gpio_pin_ingate (
    input  logic pad_in,
    input  logic ie,
    input  logic i2c_act,
    input  logic pci_act,
    output logic port_rdata,
    output logic scl_in,
    output logic pci_in
);

    logic gated;

    always_comb begin
        gated      = pad_in & ie;
        port_rdata = gated;
        scl_in     = gated & i2c_act;
        pci_in     = gated & pci_act;
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int NUM_AN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              wr_dir,
    input  logic              wr_data,
    input  logic              wr_pull,
    input  logic              wr_od,
    input  logic              i2c_en,
    input  logic              scl_out,
    input  logic              tmr_en,
    input  logic              tmr_out,
    input  logic              pci_en,
    input  logic [NUM_AN-1:0] an_sel,
    input  logic              aref_en,
    input  logic              cpu_rd_n,
    input  logic              pad_in,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pad_pu,
    output logic              pad_ie,
    output logic              port_rdata,
    output logic              scl_in,
    output logic              pci_in,
    output logic [NUM_AN-1:0] an_eff
);

    pin_cfg_t wr_cfg;
    pin_cfg_t cfg_q;
    logic     i2c_act;
    logic     pci_act;

    assign wr_cfg = '{dir: wr_dir, data: wr_data, pull: wr_pull, od: wr_od};

    gpio_pin_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (wr_cfg),
        .cfg_q (cfg_q)
    );

    gpio_pin_arb #(.NUM_AN(NUM_AN)) u_arb (
        .cfg      (cfg_q),
        .i2c_en   (i2c_en),
        .scl_out  (scl_out),
        .tmr_en   (tmr_en),
        .tmr_out  (tmr_out),
        .pci_en   (pci_en),
        .an_sel   (an_sel),
        .aref_en  (aref_en),
        .cpu_rd_n (cpu_rd_n),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu),
        .pad_ie   (pad_ie),
        .i2c_act  (i2c_act),
        .pci_act  (pci_act),
        .an_eff   (an_eff)
    );

    gpio_pin_ingate u_gate (
        .pad_in     (pad_in),
        .ie         (pad_ie),
        .i2c_act    (i2c_act),
        .pci_act    (pci_act),
        .port_rdata (port_rdata),
        .scl_in     (scl_in),
        .pci_in     (pci_in)
    );

endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk #(
    parameter int NUM_AN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              wr_pull,
    input logic              od_bit,
    input logic              i2c_en,
    input logic              pci_en,
    input logic [NUM_AN-1:0] an_sel,
    input logic              aref_en,
    input logic              cpu_rd_n,
    input logic              pad_oe,
    input logic              pad_out,
    input logic              pad_pu,
    input logic              pad_ie,
    input logic              port_rdata,
    input logic              scl_in,
    input logic              pci_in,
    input logic [NUM_AN-1:0] an_eff
);

    a_r2_pullup_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pad_pu == $past(wr_pull)));

    a_r5_od_sinks_only: assert property (@(posedge clk) disable iff (!rst_n)
        (od_bit && pad_oe) |-> !pad_out);

    a_r6_i2c_sinks_only: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_en && !aref_en && pad_oe) |-> !pad_out);

    a_r7_blocked_driver: assert property (@(posedge clk) disable iff (!rst_n)
        ((pci_en || (|an_sel) || aref_en)) |-> !pad_oe);

    a_r9_strobed_input: assert property (@(posedge clk) disable iff (!rst_n)
        (!i2c_en && !pci_en && (an_sel == '0) && !aref_en) |-> (pad_ie == !cpu_rd_n));

    a_r10_analog_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (|an_eff) |-> !pad_ie);

    a_r11_ref_override: assert property (@(posedge clk) disable iff (!rst_n)
        aref_en |-> (!pad_oe && !pad_ie && (an_eff == '0)));

    a_r12_clean_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_ie |-> (!port_rdata && !scl_in && !pci_in));

endmodule

bind gpio_pin_ctrl gpio_pin_chk #(.NUM_AN(NUM_AN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .wr_pull    (wr_pull),
    .od_bit     (cfg_q.od),
    .i2c_en     (i2c_en),
    .pci_en     (pci_en),
    .an_sel     (an_sel),
    .aref_en    (aref_en),
    .cpu_rd_n   (cpu_rd_n),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .pad_ie     (pad_ie),
    .port_rdata (port_rdata),
    .scl_in     (scl_in),
    .pci_in     (pci_in),
    .an_eff     (an_eff)
);

// File: tb/sim_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_pin_ctrl;

    localparam int NUM_AN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, wr_dir = 0, wr_data = 0, wr_pull = 0, wr_od = 0;
    logic i2c_en = 0, scl_out = 0, tmr_en = 0, tmr_out = 0, pci_en = 0;
    logic [NUM_AN-1:0] an_sel = '0;
    logic aref_en = 0, cpu_rd_n = 1, pad_in = 0;
    logic pad_oe, pad_out, pad_pu, pad_ie, port_rdata, scl_in, pci_in;
    logic [NUM_AN-1:0] an_eff;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // Model state of the configuration bits
    bit m_dir = 0, m_data = 0, m_pull = 0, m_od = 0;

    always #10 clk = ~clk;

    gpio_pin_ctrl #(.NUM_AN(NUM_AN)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .wr_dir(wr_dir), .wr_data(wr_data), .wr_pull(wr_pull), .wr_od(wr_od),
        .i2c_en(i2c_en), .scl_out(scl_out), .tmr_en(tmr_en), .tmr_out(tmr_out),
        .pci_en(pci_en), .an_sel(an_sel), .aref_en(aref_en),
        .cpu_rd_n(cpu_rd_n), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie),
        .port_rdata(port_rdata), .scl_in(scl_in), .pci_in(pci_in), .an_eff(an_eff)
    );

    // R13: model loads only on an edge with the strobe high
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir <= 0; m_data <= 0; m_pull <= 0; m_od <= 0;
        end else if (cfg_we) begin
            m_dir <= wr_dir; m_data <= wr_data; m_pull <= wr_pull; m_od <= wr_od;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] act=%b exp=%b at %0t", req, tag, act, exp, $time);
        end
    endtask

    // Behavioural expectation, compared on every falling edge after reset
    always @(negedge clk) begin
        if (rst_n) begin
            bit ie_e, oe_e, out_e, i2c_e, tmr_e, pci_e, an_e, od, sel, drv, rd;
            i2c_e = i2c_en && !aref_en;
            tmr_e = tmr_en && !aref_en;
            pci_e = pci_en && !aref_en;
            an_e  = (an_sel != 0) && !aref_en;
            if (i2c_e) sel = scl_out;
            else if (tmr_e) sel = tmr_out;
            else sel = m_data;
            od  = m_od || i2c_e;
            drv = m_dir && !(pci_e || an_e || aref_en);
            if (od) begin oe_e = drv && !sel; out_e = 0; end
            else    begin oe_e = drv; out_e = sel; end
            if (aref_en || an_e) ie_e = 0;
            else if (i2c_e || pci_e) ie_e = 1;
            else ie_e = !cpu_rd_n;
            rd = pad_in && ie_e;
            chk("R4 R5 R7", pad_oe, oe_e);
            chk("R3 R5 R6", pad_out, out_e);
            chk("R2", pad_pu, m_pull);
            chk("R8 R9 R10", pad_ie, ie_e);
            chk("R12", port_rdata, rd);
            chk("R12", scl_in, rd && i2c_e);
            chk("R12", pci_in, rd && pci_e);
            chk("R11", an_eff[0], an_sel[0] && !aref_en);
            chk("R11", an_eff[1], an_sel[1] && !aref_en);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input bit d, input bit v, input bit p, input bit o);
        cfg_we = 1; wr_dir = d; wr_data = v; wr_pull = p; wr_od = o;
        step();
        cfg_we = 0;
    endtask

    task automatic clear_fn();
        i2c_en = 0; scl_out = 0; tmr_en = 0; tmr_out = 0; pci_en = 0;
        an_sel = '0; aref_en = 0; cpu_rd_n = 1; pad_in = 0;
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #25 rst_n = 1;
        step();
        tag = "R1 reset";
        chk("R1", pad_oe, 1'b0);
        chk("R1", pad_pu, 1'b0);
        cpu_rd_n = 0; step();
        tag = "R1 R9 strobe"; pad_in = 1; step();
        cpu_rd_n = 1; step();
        tag = "R13 held without strobe";
        wr_dir = 1; wr_pull = 1; step(); step();
        tag = "R4 push-pull"; wr(1, 1, 1, 0); step(); wr(1, 0, 0, 0); step();
        tag = "R5 open-drain"; wr(1, 1, 0, 1); step(); wr(1, 0, 0, 1); step();
        tag = "R6 i2c forced od"; wr(1, 1, 0, 0);
        i2c_en = 1; scl_out = 0; step(); scl_out = 1; step();
        tag = "R3 timer priority"; i2c_en = 0; tmr_en = 1; tmr_out = 0; step();
        i2c_en = 1; scl_out = 1; step(); clear_fn();
        tag = "R7 R8 pci"; pci_en = 1; pad_in = 1; step(); clear_fn();
        tag = "R10 analog"; an_sel = 2'b01; i2c_en = 1; cpu_rd_n = 0; pad_in = 1; step(); clear_fn();
        tag = "R11 reference"; aref_en = 1; an_sel = 2'b11; i2c_en = 1; pci_en = 1; tmr_en = 1; step(); clear_fn();
        tag = "sweep";
        for (int k = 0; k < (1 << 15); k++) begin
            {cfg_we, wr_dir, wr_data, wr_pull, wr_od, i2c_en, scl_out, tmr_en,
             tmr_out, pci_en, an_sel, aref_en, cpu_rd_n, pad_in} = k[14:0];
            step();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule